// File: doc/BRIEF.md
# Two-Slot Context Submission Scheduler

This block tracks context submissions for a single engine. It has two submission slots, and each slot holds a pair of context descriptors. When a bundle of two descriptors arrives, the block checks it and then does one of three things. It can start the bundle right away. It can let the bundle take over from the current work through a lite restore. Or it can park the bundle as pending. The block also takes completion notices for the context that is currently running. It then advances within the bundle (an element switch) or retires the bundle and promotes the pending one.

From its running slot, pending slot and running element, the block drives a 64-bit execution status word. Each transition puts out one context-status event on a single-cycle strobe, for a separate status-buffer writer. The event carries a flag set, a context id and a defer-interrupt bit. A retirement that promotes a pending bundle produces two events on consecutive cycles. The first is active-to-idle with its interrupt deferred. The second is idle-to-active, which does raise the interrupt.

A descriptor is 38 bits wide with this layout:

| Bit(s) | Field |
|---|---|
| 37 | valid |
| 36 | privilege-access |
| 35:20 | context id |
| 19:0 | context address |

Two descriptors match only when both the id and the address are equal.

Top module: `ctx_slot_sched`

## Requirements
- R1: A submission is rejected when descriptor 0 has its valid bit (bit 37) clear, or when any descriptor with its valid bit set has its privilege bit (bit 36) clear. A rejection makes `sub_reject` high in the cycle after the request, and nothing else changes: no event, no status change.
- R2: A submission arriving while the queue-full status bit (bit 6) is set is rejected in the same way.
- R3: When nothing is running, an accepted bundle is stored in the slot named by the status write pointer (bit 1). That slot becomes running with descriptor 0 as the running context. The block emits idle-to-active (flag bit 0) with context id 0.
- R4: A bundle that arrives while a slot is running takes over immediately in either of two cases, and the block then emits lite-restore plus preempted (flag bits 5 and 1) with the new descriptor 0's id:
  - case (a): running descriptor 1 is valid, it matches new descriptor 0, and running descriptor 0 is not the running context;
  - case (b): running descriptor 1 is invalid and running descriptor 0 matches new descriptor 0.
- R5: Any other accepted bundle that arrives while a slot is running becomes pending. The block emits no event and sets queue-full.
- R6: A completion notice that does not match the running context (in id and address), or that arrives while nothing is running, makes `done_error` high in the next cycle. It changes no state and emits no event.
- R7: When descriptor 0 completes and descriptor 1 is valid, descriptor 1 becomes the running context. The block emits context-complete plus element-switch (flag bits 4 and 2) with the completed id.
- R8: When the last valid descriptor completes, the block emits context-complete plus active-to-idle (flag bits 4 and 3) with the completed id. The pending slot, if any, becomes running and pending is cleared. If a pending slot existed, `evt_defer_irq` is set on that event, and idle-to-active with id 0 follows in the next cycle with `evt_defer_irq` clear.
- R9: The status word is laid out as follows:
  - bit 0 is the current slot pointer;
  - bit 1 is the write pointer, the inverse of the current pointer once anything has run;
  - bits 2/3 are the valid bits and bits 4/5 the active bits for slot 0/1, set only for the running slot;
  - bit 6 is queue-full;
  - bits 63:32 are the running context id, or 0 when idle.
  When nothing runs, both pointers hold their last values.
- R10: A completion notice whose accompanying next-queued descriptor is flagged present and matches the completed one is ignored entirely: no event, no error, no status change.
- R11: After reset the status word is all zeros, no event is presented and both slots are empty.
- R12: At most one event is presented per cycle. Each event lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sub_valid | input | 1 | Submission request strobe |
| sub_desc0 | input | 38 | Bundle descriptor 0 |
| sub_desc1 | input | 38 | Bundle descriptor 1 |
| done_valid | input | 1 | Completion notice strobe |
| done_desc | input | 38 | Descriptor of the context that completed |
| done_next_vld | input | 1 | A next queued context is present |
| done_next_desc | input | 38 | Descriptor of the next queued context |
| sub_reject | output | 1 | Pulse: the previous submission was refused |
| done_error | output | 1 | Pulse: the previous completion did not match the running context |
| exec_status | output | 64 | Execution status word |
| evt_valid | output | 1 | Context-status event strobe |
| evt_flags | output | 6 | Event flags: 0 idle-to-active, 1 preempted, 2 element switch, 3 active-to-idle, 4 context complete, 5 lite restore |
| evt_ctx_id | output | 16 | Context id carried by the event |
| evt_defer_irq | output | 1 | The interrupt for this event is deferred |

## Verification
The checker takes two things for granted about the inputs. First, a submission and a completion never arrive in the same cycle. Second, no request is presented in the cycle where a deferred-interrupt event is visible, because that is the cycle the follow-up event is being issued. The directed tasks present one request at a time and return the inputs to idle at the next falling edge. The two-event retirement task then waits for the follow-up event before the next scenario starts, so both assumptions hold throughout the stimulus.

// File: rtl/ctx_slot_pkg.sv
package ctx_slot_pkg;
  parameter int unsigned CTX_ID_W   = 16;
  parameter int unsigned CTX_ADDR_W = 20;
  parameter int unsigned NSLOT      = 2;
  localparam int unsigned SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int unsigned DESC_W    = 2 + CTX_ID_W + CTX_ADDR_W;
  localparam int unsigned STAT_W    = 64;
  localparam int unsigned EVT_W     = 6;

  // event flag positions
  localparam int unsigned EV_IDLE2ACT = 0;
  localparam int unsigned EV_PREEMPT  = 1;
  localparam int unsigned EV_ELEM_SW  = 2;
  localparam int unsigned EV_ACT2IDLE = 3;
  localparam int unsigned EV_COMPLETE = 4;
  localparam int unsigned EV_LITE     = 5;

  // status word positions
  localparam int unsigned ST_CUR    = 0;
  localparam int unsigned ST_WP     = 1;
  localparam int unsigned ST_VLD0   = 2;
  localparam int unsigned ST_ACT0   = 4;
  localparam int unsigned ST_QFULL  = 6;
  localparam int unsigned ST_ID_LSB = 32;

  typedef struct packed {
    logic                  vld;
    logic                  priv;
    logic [CTX_ID_W-1:0]   id;
    logic [CTX_ADDR_W-1:0] addr;
  } desc_t;

  function automatic logic same_ctx(desc_t a, desc_t b);
    return (a.id == b.id) && (a.addr == b.addr);
  endfunction
endpackage

// File: rtl/ctx_slot_store.sv
module ctx_slot_store
  import ctx_slot_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SLOT_W-1:0]      wr_slot,
  input  desc_t                  wr_d0,
  input  desc_t                  wr_d1,
  output desc_t [NSLOT-1:0]      rd_d0,
  output desc_t [NSLOT-1:0]      rd_d1
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    desc_t d0_q, d1_q;
    logic  ld;
    assign ld = wr_en && (wr_slot == SLOT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d0_q <= '0;
        d1_q <= '0;
      end else if (ld) begin
        d0_q <= wr_d0;
        d1_q <= wr_d1;
      end
    end
    assign rd_d0[s] = d0_q;
    assign rd_d1[s] = d1_q;
  end
endmodule

// File: rtl/ctx_sched_ctrl.sv
module ctx_sched_ctrl
  import ctx_slot_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sub_valid,
  input  desc_t                 sub_d0,
  input  desc_t                 sub_d1,
  input  logic                  done_valid,
  input  desc_t                 done_d,
  input  logic                  done_nxt_vld,
  input  desc_t                 done_nxt_d,
  input  desc_t [NSLOT-1:0]     rd_d0,
  input  desc_t [NSLOT-1:0]     rd_d1,
  output logic                  wr_en,
  output logic [SLOT_W-1:0]     wr_slot,
  output logic                  run_vld,
  output logic [SLOT_W-1:0]     run_slot,
  output logic                  pend_vld,
  output logic [SLOT_W-1:0]     cur_ptr,
  output logic [SLOT_W-1:0]     wr_ptr,
  output logic [CTX_ID_W-1:0]   run_id,
  output logic                  req_vld,
  output logic [EVT_W-1:0]      req_flags,
  output logic [CTX_ID_W-1:0]   req_id,
  output logic                  req_defer,
  output logic                  req_follow,
  output logic                  sub_reject,
  output logic                  done_error
);
  logic              run_vld_q, run_vld_n;
  logic [SLOT_W-1:0] run_slot_q, run_slot_n;
  logic              run_elem_q, run_elem_n;
  logic              pend_vld_q, pend_vld_n;
  logic [SLOT_W-1:0] pend_slot_q, pend_slot_n;
  logic [SLOT_W-1:0] cur_q, cur_n;
  logic [SLOT_W-1:0] wp_q, wp_n;
  logic              rej_q, rej_n;
  logic              err_q, err_n;

  desc_t r0, r1, run_ctx;
  logic  sub_bad, lite_a, lite_b, suppress;

  assign r0      = rd_d0[run_slot_q];
  assign r1      = rd_d1[run_slot_q];
  assign run_ctx = run_elem_q ? r1 : r0;

  assign sub_bad  = !sub_d0.vld || (sub_d0.vld && !sub_d0.priv) ||
                    (sub_d1.vld && !sub_d1.priv);
  assign lite_a   = r1.vld && same_ctx(r1, sub_d0) && !same_ctx(r0, run_ctx);
  assign lite_b   = !r1.vld && same_ctx(r0, sub_d0);
  assign suppress = done_nxt_vld && same_ctx(done_d, done_nxt_d);

  always_comb begin
    run_vld_n   = run_vld_q;
    run_slot_n  = run_slot_q;
    run_elem_n  = run_elem_q;
    pend_vld_n  = pend_vld_q;
    pend_slot_n = pend_slot_q;
    cur_n       = cur_q;
    wp_n        = wp_q;
    rej_n       = 1'b0;
    err_n       = 1'b0;
    wr_en       = 1'b0;
    wr_slot     = wp_q;
    req_vld     = 1'b0;
    req_flags   = '0;
    req_id      = '0;
    req_defer   = 1'b0;
    req_follow  = 1'b0;
    if (sub_valid) begin
      if (sub_bad || pend_vld_q) begin
        rej_n = 1'b1;
      end else begin
        wr_en = 1'b1;
        if (!run_vld_q) begin
          run_vld_n  = 1'b1;
          run_slot_n = wp_q;
          run_elem_n = 1'b0;
          pend_vld_n = 1'b0;
          cur_n      = wp_q;
          wp_n       = ~wp_q;
          req_vld    = 1'b1;
          req_flags[EV_IDLE2ACT] = 1'b1;
        end else if (lite_a || lite_b) begin
          run_slot_n = wp_q;
          run_elem_n = 1'b0;
          pend_vld_n = 1'b0;
          cur_n      = wp_q;
          wp_n       = ~wp_q;
          req_vld    = 1'b1;
          req_flags[EV_LITE]    = 1'b1;
          req_flags[EV_PREEMPT] = 1'b1;
          req_id     = sub_d0.id;
        end else begin
          pend_vld_n  = 1'b1;
          pend_slot_n = wp_q;
        end
      end
    end else if (done_valid && !suppress) begin
      if (!run_vld_q || !same_ctx(done_d, run_ctx)) begin
        err_n = 1'b1;
      end else if (!run_elem_q && r1.vld) begin
        run_elem_n = 1'b1;
        req_vld    = 1'b1;
        req_flags[EV_COMPLETE] = 1'b1;
        req_flags[EV_ELEM_SW]  = 1'b1;
        req_id     = done_d.id;
      end else begin
        run_elem_n = 1'b0;
        pend_vld_n = 1'b0;
        req_vld    = 1'b1;
        req_flags[EV_COMPLETE] = 1'b1;
        req_flags[EV_ACT2IDLE] = 1'b1;
        req_id     = done_d.id;
        if (pend_vld_q) begin
          run_slot_n = pend_slot_q;
          cur_n      = pend_slot_q;
          wp_n       = ~pend_slot_q;
          req_defer  = 1'b1;
          req_follow = 1'b1;
        end else begin
          run_vld_n  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_vld_q   <= 1'b0;
      run_slot_q  <= '0;
      run_elem_q  <= 1'b0;
      pend_vld_q  <= 1'b0;
      pend_slot_q <= '0;
      cur_q       <= '0;
      wp_q        <= '0;
      rej_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      run_vld_q   <= run_vld_n;
      run_slot_q  <= run_slot_n;
      run_elem_q  <= run_elem_n;
      pend_vld_q  <= pend_vld_n;
      pend_slot_q <= pend_slot_n;
      cur_q       <= cur_n;
      wp_q        <= wp_n;
      rej_q       <= rej_n;
      err_q       <= err_n;
    end
  end

  assign run_vld    = run_vld_q;
  assign run_slot   = run_slot_q;
  assign pend_vld   = pend_vld_q;
  assign cur_ptr    = cur_q;
  assign wr_ptr     = wp_q;
  assign run_id     = run_vld_q ? run_ctx.id : '0;
  assign sub_reject = rej_q;
  assign done_error = err_q;
endmodule

// File: rtl/ctx_evt_out.sv
module ctx_evt_out
  import ctx_slot_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_vld,
  input  logic [EVT_W-1:0]    req_flags,
  input  logic [CTX_ID_W-1:0] req_id,
  input  logic                req_defer,
  input  logic                req_follow,
  output logic                evt_valid,
  output logic [EVT_W-1:0]    evt_flags,
  output logic [CTX_ID_W-1:0] evt_ctx_id,
  output logic                evt_defer_irq
);
  logic                vld_q, vld_n;
  logic [EVT_W-1:0]    flg_q, flg_n;
  logic [CTX_ID_W-1:0] id_q, id_n;
  logic                dfr_q, dfr_n;
  logic                fol_q, fol_n;

  always_comb begin
    vld_n = 1'b0;
    flg_n = '0;
    id_n  = '0;
    dfr_n = 1'b0;
    fol_n = 1'b0;
    if (fol_q) begin
      vld_n = 1'b1;
      flg_n[EV_IDLE2ACT] = 1'b1;
    end else if (req_vld) begin
      vld_n = 1'b1;
      flg_n = req_flags;
      id_n  = req_id;
      dfr_n = req_defer;
      fol_n = req_follow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      flg_q <= '0;
      id_q  <= '0;
      dfr_q <= 1'b0;
      fol_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
      flg_q <= flg_n;
      id_q  <= id_n;
      dfr_q <= dfr_n;
      fol_q <= fol_n;
    end
  end

  assign evt_valid     = vld_q;
  assign evt_flags     = flg_q;
  assign evt_ctx_id    = id_q;
  assign evt_defer_irq = dfr_q;
endmodule

// File: rtl/ctx_slot_sched.sv
module ctx_slot_sched
  import ctx_slot_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sub_valid,
  input  logic [DESC_W-1:0]   sub_desc0,
  input  logic [DESC_W-1:0]   sub_desc1,
  input  logic                done_valid,
  input  logic [DESC_W-1:0]   done_desc,
  input  logic                done_next_vld,
  input  logic [DESC_W-1:0]   done_next_desc,
  output logic                sub_reject,
  output logic                done_error,
  output logic [STAT_W-1:0]   exec_status,
  output logic                evt_valid,
  output logic [EVT_W-1:0]    evt_flags,
  output logic [CTX_ID_W-1:0] evt_ctx_id,
  output logic                evt_defer_irq
);
  desc_t [NSLOT-1:0]   rd_d0, rd_d1;
  logic                wr_en;
  logic [SLOT_W-1:0]   wr_slot;
  logic                run_vld, pend_vld;
  logic [SLOT_W-1:0]   run_slot, cur_ptr, wr_ptr;
  logic [CTX_ID_W-1:0] run_id;
  logic                req_vld, req_defer, req_follow;
  logic [EVT_W-1:0]    req_flags;
  logic [CTX_ID_W-1:0] req_id;

  ctx_slot_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_d0   (desc_t'(sub_desc0)),
    .wr_d1   (desc_t'(sub_desc1)),
    .rd_d0   (rd_d0),
    .rd_d1   (rd_d1)
  );

  ctx_sched_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sub_valid    (sub_valid),
    .sub_d0       (desc_t'(sub_desc0)),
    .sub_d1       (desc_t'(sub_desc1)),
    .done_valid   (done_valid),
    .done_d       (desc_t'(done_desc)),
    .done_nxt_vld (done_next_vld),
    .done_nxt_d   (desc_t'(done_next_desc)),
    .rd_d0        (rd_d0),
    .rd_d1        (rd_d1),
    .wr_en        (wr_en),
    .wr_slot      (wr_slot),
    .run_vld      (run_vld),
    .run_slot     (run_slot),
    .pend_vld     (pend_vld),
    .cur_ptr      (cur_ptr),
    .wr_ptr       (wr_ptr),
    .run_id       (run_id),
    .req_vld      (req_vld),
    .req_flags    (req_flags),
    .req_id       (req_id),
    .req_defer    (req_defer),
    .req_follow   (req_follow),
    .sub_reject   (sub_reject),
    .done_error   (done_error)
  );

  ctx_evt_out u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_vld       (req_vld),
    .req_flags     (req_flags),
    .req_id        (req_id),
    .req_defer     (req_defer),
    .req_follow    (req_follow),
    .evt_valid     (evt_valid),
    .evt_flags     (evt_flags),
    .evt_ctx_id    (evt_ctx_id),
    .evt_defer_irq (evt_defer_irq)
  );

  always_comb begin
    exec_status = '0;
    exec_status[ST_CUR] = cur_ptr[0];
    exec_status[ST_WP]  = wr_ptr[0];
    for (int s = 0; s < NSLOT; s++) begin
      exec_status[ST_VLD0 + s] = run_vld && (run_slot == SLOT_W'(s));
      exec_status[ST_ACT0 + s] = run_vld && (run_slot == SLOT_W'(s));
    end
    exec_status[ST_QFULL] = pend_vld;
    exec_status[ST_ID_LSB +: CTX_ID_W] = run_id;
  end
endmodule

// File: rtl/ctx_slot_sched_chk.sv
module ctx_slot_sched_chk
  import ctx_slot_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sub_valid,
  input logic                done_valid,
  input logic                sub_reject,
  input logic                done_error,
  input logic [STAT_W-1:0]   exec_status,
  input logic                evt_valid,
  input logic [EVT_W-1:0]    evt_flags,
  input logic [CTX_ID_W-1:0] evt_ctx_id,
  input logic                evt_defer_irq
);
  localparam logic [EVT_W-1:0] F_IDLE = EVT_W'(1) << EV_IDLE2ACT;

  AST_IN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sub_valid && done_valid));
  AST_IN_QUIET_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_defer_irq) |-> !(sub_valid || done_valid)); // R8
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reject |-> !evt_valid); // R1
  AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && exec_status[ST_QFULL]) |=> sub_reject); // R2
  AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_flags == F_IDLE) |-> (evt_ctx_id == '0)); // R3
  AST_LITE_RUNS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_flags[EV_LITE]) |->
      (exec_status[ST_ID_LSB +: CTX_ID_W] == evt_ctx_id)); // R4
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_error |-> ($stable(exec_status) && !evt_valid)); // R6
  AST_DEFER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_defer_irq) |=>
      (evt_valid && evt_flags == F_IDLE && !evt_defer_irq)); // R8
  AST_QFULL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    exec_status[ST_QFULL] |-> (exec_status[ST_VLD0] || exec_status[ST_VLD0+1])); // R9
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(exec_status[ST_ACT0 +: NSLOT])); // R9
  AST_EVT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_flags != '0)); // R12
endmodule

bind ctx_slot_sched ctx_slot_sched_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sub_valid     (sub_valid),
  .done_valid    (done_valid),
  .sub_reject    (sub_reject),
  .done_error    (done_error),
  .exec_status   (exec_status),
  .evt_valid     (evt_valid),
  .evt_flags     (evt_flags),
  .evt_ctx_id    (evt_ctx_id),
  .evt_defer_irq (evt_defer_irq)
);

// File: tb/ctx_slot_sched_tb.sv
module ctx_slot_sched_tb;
  import ctx_slot_pkg::*;

  localparam logic [5:0] F_IDLE = 6'b000001;
  localparam logic [5:0] F_LITE = 6'b100010;
  localparam logic [5:0] F_ELEM = 6'b010100;
  localparam logic [5:0] F_A2I  = 6'b011000;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                sub_valid, done_valid, done_next_vld;
  logic [DESC_W-1:0]   sub_desc0, sub_desc1, done_desc, done_next_desc;
  logic                sub_reject, done_error;
  logic [STAT_W-1:0]   exec_status;
  logic                evt_valid, evt_defer_irq;
  logic [EVT_W-1:0]    evt_flags;
  logic [CTX_ID_W-1:0] evt_ctx_id;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  ctx_slot_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .sub_valid(sub_valid), .sub_desc0(sub_desc0), .sub_desc1(sub_desc1),
    .done_valid(done_valid), .done_desc(done_desc),
    .done_next_vld(done_next_vld), .done_next_desc(done_next_desc),
    .sub_reject(sub_reject), .done_error(done_error), .exec_status(exec_status),
    .evt_valid(evt_valid), .evt_flags(evt_flags), .evt_ctx_id(evt_ctx_id),
    .evt_defer_irq(evt_defer_irq)
  );

  function automatic logic [DESC_W-1:0] mk(logic v, logic p, logic [15:0] id, logic [19:0] a);
    return {v, p, id, a};
  endfunction

  function automatic logic [63:0] st(logic cur, logic wp, logic run, logic slot,
                                     logic qf, logic [15:0] id);
    logic [63:0] r;
    r = '0;
    r[0] = cur; r[1] = wp;
    r[2] = run && !slot; r[3] = run && slot;
    r[4] = run && !slot; r[5] = run && slot;
    r[6] = qf;
    r[47:32] = id;
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_evt(string req, logic v, logic [5:0] f, logic [15:0] id, logic d);
    chk(req, {evt_valid, evt_flags, evt_ctx_id, evt_defer_irq}, {v, f, id, d});
  endtask

  task automatic do_sub(logic [DESC_W-1:0] d0, logic [DESC_W-1:0] d1);
    @(negedge clk);
    sub_valid = 1'b1; sub_desc0 = d0; sub_desc1 = d1;
    @(posedge clk); #1;
    @(negedge clk);
    sub_valid = 1'b0;
  endtask

  task automatic do_done(logic [DESC_W-1:0] d, logic nv, logic [DESC_W-1:0] nd);
    @(negedge clk);
    done_valid = 1'b1; done_desc = d; done_next_vld = nv; done_next_desc = nd;
    @(posedge clk); #1;
    @(negedge clk);
    done_valid = 1'b0; done_next_vld = 1'b0;
  endtask

  // descriptors
  logic [DESC_W-1:0] dA, dB, dC, dD, dE, dF, dG, dNone;

  // Sample point helper: results appear after the request edge; tasks return at
  // the following negedge, half a cycle later, with outputs still held.
  task automatic t_reset;
    chk("R11 status", exec_status, 64'h0);
    chk_evt("R11 event", 1'b0, 6'h0, 16'h0, 1'b0);
  endtask

  task automatic t_bad_desc;
    do_sub(mk(1'b0, 1'b1, 16'h11, 20'h100), dNone);
    chk("R1 d0 invalid reject", {63'h0, sub_reject}, 64'h1);
    chk("R1 d0 invalid status", exec_status, 64'h0);
    do_sub(mk(1'b1, 1'b0, 16'h11, 20'h100), dNone);
    chk("R1 d0 priv reject", {63'h0, sub_reject}, 64'h1);
    do_sub(dA, mk(1'b1, 1'b0, 16'h22, 20'h200));
    chk("R1 d1 priv reject", {63'h0, sub_reject}, 64'h1);
    chk_evt("R1 no event", 1'b0, 6'h0, 16'h0, 1'b0);
    chk("R1 status kept", exec_status, 64'h0);
  endtask

  task automatic t_start_and_pend;
    do_sub(dA, dB);
    chk_evt("R3 idle-to-active", 1'b1, F_IDLE, 16'h0, 1'b0);
    chk("R3/R9 status", exec_status, st(0, 1, 1, 0, 0, 16'h11));
    do_sub(dC, dD);
    chk_evt("R5 no event", 1'b0, 6'h0, 16'h0, 1'b0);
    chk("R5 pending status", exec_status, st(0, 1, 1, 0, 1, 16'h11));
    do_sub(dE, dNone);
    chk("R2 full reject", {63'h0, sub_reject}, 64'h1);
    chk("R2 status kept", exec_status, st(0, 1, 1, 0, 1, 16'h11));
  endtask

  task automatic t_complete_seq;
    do_done(mk(1'b1, 1'b1, 16'h11, 20'h999), 1'b0, dNone);
    chk("R6 addr mismatch error", {63'h0, done_error}, 64'h1);
    chk_evt("R6 no event", 1'b0, 6'h0, 16'h0, 1'b0);
    chk("R6 status kept", exec_status, st(0, 1, 1, 0, 1, 16'h11));
    do_done(dA, 1'b0, dNone);
    chk_evt("R7 element switch", 1'b1, F_ELEM, 16'h11, 1'b0);
    chk("R7 status", exec_status, st(0, 1, 1, 0, 1, 16'h22));
    do_done(dB, 1'b1, dB);
    chk_evt("R10 suppressed", 1'b0, 6'h0, 16'h0, 1'b0);
    chk("R10 no error", {63'h0, done_error}, 64'h0);
    chk("R10 status kept", exec_status, st(0, 1, 1, 0, 1, 16'h22));
    @(negedge clk);
    done_valid = 1'b1; done_desc = dB; done_next_vld = 1'b1; done_next_desc = dC;
    @(posedge clk); #1;
    done_valid = 1'b0; done_next_vld = 1'b0;
    chk_evt("R8 active-to-idle deferred", 1'b1, F_A2I, 16'h22, 1'b1);
    chk("R8 promote status", exec_status, st(1, 0, 1, 1, 0, 16'h33));
    @(posedge clk); #1;
    chk_evt("R8 follow idle-to-active", 1'b1, F_IDLE, 16'h0, 1'b0);
    @(posedge clk); #1;
    chk_evt("R12 single cycle", 1'b0, 6'h0, 16'h0, 1'b0);
  endtask

  task automatic t_lite_a;
    do_done(dC, 1'b0, dNone);
    chk_evt("R7 switch to D", 1'b1, F_ELEM, 16'h33, 1'b0);
    do_sub(dD, dE);
    chk_evt("R4 case a lite", 1'b1, F_LITE, 16'h44, 1'b0);
    chk("R4 case a status", exec_status, st(0, 1, 1, 0, 0, 16'h44));
    do_done(dD, 1'b0, dNone);
    chk_evt("R7 switch to E", 1'b1, F_ELEM, 16'h44, 1'b0);
    do_done(dE, 1'b0, dNone);
    chk_evt("R8 idle no defer", 1'b1, F_A2I, 16'h55, 1'b0);
    chk("R9 idle holds pointers", exec_status, st(0, 1, 0, 0, 0, 16'h0));
    @(posedge clk); #1;
    chk_evt("R8 no follow", 1'b0, 6'h0, 16'h0, 1'b0);
    do_done(dE, 1'b0, dNone);
    chk("R6 idle completion error", {63'h0, done_error}, 64'h1);
  endtask

  task automatic t_lite_b;
    do_sub(dF, dNone);
    chk_evt("R3 slot 1 start", 1'b1, F_IDLE, 16'h0, 1'b0);
    chk("R3 slot 1 status", exec_status, st(1, 0, 1, 1, 0, 16'h66));
    do_sub(dF, dG);
    chk_evt("R4 case b lite", 1'b1, F_LITE, 16'h66, 1'b0);
    chk("R4 case b status", exec_status, st(0, 1, 1, 0, 0, 16'h66));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    dA = mk(1, 1, 16'h11, 20'h100); dB = mk(1, 1, 16'h22, 20'h200);
    dC = mk(1, 1, 16'h33, 20'h300); dD = mk(1, 1, 16'h44, 20'h400);
    dE = mk(1, 1, 16'h55, 20'h500); dF = mk(1, 1, 16'h66, 20'h600);
    dG = mk(1, 1, 16'h77, 20'h700); dNone = '0;
    rst_n = 1'b0; sub_valid = 1'b0; done_valid = 1'b0; done_next_vld = 1'b0;
    sub_desc0 = '0; sub_desc1 = '0; done_desc = '0; done_next_desc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_desc();
    t_start_and_pend();
    t_complete_seq();
    t_lite_a();
    t_lite_b();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule